// File: doc/BRIEF.md
# Logic Analyzer Trigger Detector

This unit watches the sample stream of a 16-channel logic analyzer and decides when a capture should be marked as triggered. In its normal mode it combines a value-and-mask state comparison across all channels with up to two single-channel transition detectors. Each detector looks for a rising or a falling transition by comparing the current sample with the sample taken on the previous sample-enable cycle. The two detector results are ORed, and that result is ANDed with the state comparison. In its fast mode the state comparison is set aside and a single pin, chosen by a small select field, is watched for one edge polarity.

Software arms the unit with a start strobe. The first matching sample then produces a one-cycle trigger pulse, sets a sticky triggered flag in a status byte and, when enabled, pulses a trigger-out pin. Further matches are ignored until the unit is armed again. The previous-sample register advances only on sample-enable cycles, so edges are judged at the divided sample rate rather than at the clock rate.

Top module: `la_trig_unit`

## Requirements
- R1: After reset trigPulse, trigOut and every bit of modeStatus are 0, and the previous-sample register holds 0.
- R2: In normal mode with both edge detectors disabled, an armed unit fires on a sample-enable cycle whose sample satisfies (sample AND matchMask) == (matchValue AND matchMask); channels whose mask bit is 0 do not affect the result.
- R3: An enabled edge detector with its rise bit set sees a transition when its selected channel (4-bit index) was 0 in the previous sample and is 1 in the current one.
- R4: An enabled edge detector with its rise bit clear sees a transition when its selected channel was 1 in the previous sample and is 0 in the current one.
- R5: With one or both edge detectors enabled, the unit fires only when the state comparison holds and at least one enabled detector sees its transition (detector results ORed).
- R6: The previous-sample register loads sampleIn only on cycles with sampleEn high; other cycles leave it unchanged.
- R7: In fast mode (fastMode = 1) the unit fires only on an edge of pin fastSel[2:0]; fastSel[3] = 1 selects a falling edge, 0 a rising edge; the state comparison and other pins have no effect.
- R8: modeStatus bit 5 is set when the unit fires and stays set until the next armStart; modeStatus bit 0 is 1 while the unit is armed; all other bits read 0.
- R9: trigOut pulses together with trigPulse when trigOutEn was high on the firing sample cycle, and stays low otherwise.
- R10: After firing, the unit ignores further matches until armStart; armStart clears the triggered flag and has priority over a match in the same cycle.
- R11: trigPulse is high for exactly one clock, in the cycle after the sample-enable edge on which the match is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | Qualifies sampleIn as a new sample |
| sampleIn | input | 16 | Current sample, one bit per channel |
| armStart | input | 1 | Start strobe: arms the unit and clears the flag |
| fastMode | input | 1 | 1 selects single-pin edge mode |
| matchValue | input | 16 | Expected levels for masked channels |
| matchMask | input | 16 | 1 marks a channel that takes part in the state comparison |
| edgeSelA | input | 4 | Channel index for edge detector A |
| edgeEnA | input | 1 | Enables edge detector A |
| edgeRiseA | input | 1 | 1 rising, 0 falling for detector A |
| edgeSelB | input | 4 | Channel index for edge detector B |
| edgeEnB | input | 1 | Enables edge detector B |
| edgeRiseB | input | 1 | 1 rising, 0 falling for detector B |
| fastSel | input | 4 | Fast mode: bits 2:0 pin index, bit 3 falling edge |
| trigOutEn | input | 1 | Enables the trigger-out pin |
| trigPulse | output | 1 | One-cycle trigger event |
| trigOut | output | 1 | Trigger-out pin |
| modeStatus | output | 8 | Bit 5 triggered, bit 0 armed |

## Verification
The bench goes after edges that straddle idle clocks: a sample stream that toggles a channel while sampleEn is low must not register an edge, so a design that loaded the previous sample every clock would fire where the reference does not. It checks that an edge without the state match stays silent and that a state match without an edge stays silent when a detector is enabled, catching a design that ORs instead of ANDs. It fires twice in a row without re-arming to catch a unit that is not one-shot, and in fast mode it toggles a neighbouring pin and sets an unsatisfiable mask to catch a design that decodes the wrong index or still applies the state term.

// File: rtl/la_trig_pkg.sv
package la_trig_pkg;
  localparam int CHANNELS    = 16;
  localparam int SEL_W       = $clog2(CHANNELS);
  localparam int FAST_IDX_W  = 3;
  localparam int STATUS_W    = 8;
  localparam int STAT_TRIG   = 5;
  localparam int STAT_ARMED  = 0;
  localparam int EDGE_SLOTS  = 2;

  typedef struct packed {
    logic capture;   // load previous-sample register
    logic evaluate;  // judge current sample for a trigger
  } trigStrobe_t;
endpackage

// File: rtl/la_trig_datapath.sv
module la_trig_datapath
  import la_trig_pkg::*;
#(
  parameter int W    = CHANNELS,
  parameter int SELW = $clog2(W),
  parameter int FW   = FAST_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  trigStrobe_t       strobes,
  input  logic [W-1:0]      sampleIn,
  input  logic              fastMode,
  input  logic [W-1:0]      matchValue,
  input  logic [W-1:0]      matchMask,
  input  logic [SELW-1:0]   edgeSelA,
  input  logic              edgeEnA,
  input  logic              edgeRiseA,
  input  logic [SELW-1:0]   edgeSelB,
  input  logic              edgeEnB,
  input  logic              edgeRiseB,
  input  logic [FW:0]       fastSel,
  output logic              hit
);
  localparam int SLOTS = EDGE_SLOTS;

  logic [W-1:0] prevSample;
  logic [W-1:0] riseVec;
  logic [W-1:0] fallVec;

  always_ff @(posedge clk) begin
    if (!rst_n)               prevSample <= '0;
    else if (strobes.capture) prevSample <= sampleIn;
  end

  assign riseVec = ~prevSample & sampleIn;
  assign fallVec = prevSample & ~sampleIn;

  logic [SELW-1:0] slotSel  [SLOTS];
  logic [SLOTS-1:0] slotEn;
  logic [SLOTS-1:0] slotRise;
  logic [SLOTS-1:0] slotSeen;

  assign slotSel[0] = edgeSelA;
  assign slotSel[1] = edgeSelB;
  assign slotEn     = {edgeEnB, edgeEnA};
  assign slotRise   = {edgeRiseB, edgeRiseA};

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign slotSeen[s] = slotEn[s] &
        (slotRise[s] ? riseVec[slotSel[s]] : fallVec[slotSel[s]]);
    end
  endgenerate

  logic stateOk;
  logic edgeOk;
  logic fastOk;
  logic [FW-1:0] fastPin;

  assign stateOk = ((sampleIn ^ matchValue) & matchMask) == '0;
  assign edgeOk  = (slotEn == '0) ? 1'b1 : (|slotSeen);
  assign fastPin = fastSel[FW-1:0];
  assign fastOk  = fastSel[FW] ? fallVec[fastPin] : riseVec[fastPin];

  assign hit = strobes.evaluate & (fastMode ? fastOk : (stateOk & edgeOk));
endmodule

// File: rtl/la_trig_control.sv
module la_trig_control
  import la_trig_pkg::*;
#(
  parameter int SW = STATUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sampleEn,
  input  logic          armStart,
  input  logic          trigOutEn,
  input  logic          hit,
  output trigStrobe_t   strobes,
  output logic          trigPulse,
  output logic          trigOut,
  output logic [SW-1:0] modeStatus
);
  logic armed;
  logic triggered;

  assign strobes.capture  = sampleEn;
  assign strobes.evaluate = armed & sampleEn & ~armStart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      triggered <= 1'b0;
      trigPulse <= 1'b0;
      trigOut   <= 1'b0;
    end else if (armStart) begin
      armed     <= 1'b1;
      triggered <= 1'b0;
      trigPulse <= 1'b0;
      trigOut   <= 1'b0;
    end else if (hit) begin
      armed     <= 1'b0;
      triggered <= 1'b1;
      trigPulse <= 1'b1;
      trigOut   <= trigOutEn;
    end else begin
      trigPulse <= 1'b0;
      trigOut   <= 1'b0;
    end
  end

  always_comb begin
    modeStatus             = '0;
    modeStatus[STAT_TRIG]  = triggered;
    modeStatus[STAT_ARMED] = armed;
  end
endmodule

// File: rtl/la_trig_unit.sv
module la_trig_unit
  import la_trig_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sampleEn,
  input  logic [CHANNELS-1:0] sampleIn,
  input  logic                armStart,
  input  logic                fastMode,
  input  logic [CHANNELS-1:0] matchValue,
  input  logic [CHANNELS-1:0] matchMask,
  input  logic [SEL_W-1:0]    edgeSelA,
  input  logic                edgeEnA,
  input  logic                edgeRiseA,
  input  logic [SEL_W-1:0]    edgeSelB,
  input  logic                edgeEnB,
  input  logic                edgeRiseB,
  input  logic [FAST_IDX_W:0] fastSel,
  input  logic                trigOutEn,
  output logic                trigPulse,
  output logic                trigOut,
  output logic [STATUS_W-1:0] modeStatus
);
  trigStrobe_t strobes;
  logic        hit;

  la_trig_datapath #(.W(CHANNELS), .SELW(SEL_W), .FW(FAST_IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .sampleIn(sampleIn),
    .fastMode(fastMode), .matchValue(matchValue), .matchMask(matchMask),
    .edgeSelA(edgeSelA), .edgeEnA(edgeEnA), .edgeRiseA(edgeRiseA),
    .edgeSelB(edgeSelB), .edgeEnB(edgeEnB), .edgeRiseB(edgeRiseB),
    .fastSel(fastSel), .hit(hit)
  );

  la_trig_control #(.SW(STATUS_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sampleEn(sampleEn), .armStart(armStart),
    .trigOutEn(trigOutEn), .hit(hit), .strobes(strobes),
    .trigPulse(trigPulse), .trigOut(trigOut), .modeStatus(modeStatus)
  );
endmodule

// File: rtl/la_trig_checker.sv
module la_trig_checker
  import la_trig_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                sampleEn,
  input logic                armStart,
  input logic                trigOutEn,
  input logic                trigPulse,
  input logic                trigOut,
  input logic [STATUS_W-1:0] modeStatus
);
  a_r11_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    trigPulse |=> !trigPulse);
  a_r11_pulse_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trigPulse) |-> $past(sampleEn));
  a_r8_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trigPulse |-> (modeStatus[STAT_TRIG] && !modeStatus[STAT_ARMED]));
  a_r9_out_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trigOut |-> trigPulse);
  a_r9_out_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trigPulse) && $past(trigOutEn) |-> trigOut);
  a_r10_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    armStart |=> (modeStatus[STAT_ARMED] && !modeStatus[STAT_TRIG] && !trigPulse));
  a_r10_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
    (modeStatus[STAT_TRIG] && !armStart) |=> !trigPulse);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (modeStatus[STAT_TRIG] && !armStart) |=> modeStatus[STAT_TRIG]);
endmodule

bind la_trig_unit la_trig_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sampleEn(sampleEn), .armStart(armStart),
  .trigOutEn(trigOutEn), .trigPulse(trigPulse), .trigOut(trigOut),
  .modeStatus(modeStatus)
);

// File: tb/la_trig_unit_tb.sv
module la_trig_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sampleEn = 1'b0;
  logic [15:0] sampleIn = '0;
  logic        armStart = 1'b0;
  logic        fastMode = 1'b0;
  logic [15:0] matchValue = '0;
  logic [15:0] matchMask = '0;
  logic [3:0]  edgeSelA = '0;
  logic        edgeEnA = 1'b0;
  logic        edgeRiseA = 1'b0;
  logic [3:0]  edgeSelB = '0;
  logic        edgeEnB = 1'b0;
  logic        edgeRiseB = 1'b0;
  logic [3:0]  fastSel = '0;
  logic        trigOutEn = 1'b0;
  logic        trigPulse;
  logic        trigOut;
  logic [7:0]  modeStatus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  la_trig_unit u_dut (
    .clk(clk), .rst_n(rst_n), .sampleEn(sampleEn), .sampleIn(sampleIn),
    .armStart(armStart), .fastMode(fastMode), .matchValue(matchValue),
    .matchMask(matchMask), .edgeSelA(edgeSelA), .edgeEnA(edgeEnA),
    .edgeRiseA(edgeRiseA), .edgeSelB(edgeSelB), .edgeEnB(edgeEnB),
    .edgeRiseB(edgeRiseB), .fastSel(fastSel), .trigOutEn(trigOutEn),
    .trigPulse(trigPulse), .trigOut(trigOut), .modeStatus(modeStatus)
  );

  // Behavioural reference model
  int  mPrev = 0;
  bit  mArmed = 0, mTrig = 0, mPulse = 0, mOut = 0;

  function automatic bit bitOf(int v, int idx);
    return ((v >> idx) & 1) == 1;
  endfunction

  function automatic bit edgeAt(int prev, int cur, int idx, bit rise);
    if (rise) return !bitOf(prev, idx) && bitOf(cur, idx);
    return bitOf(prev, idx) && !bitOf(cur, idx);
  endfunction

  always @(posedge clk) begin
    int cur;
    bit fire;
    cur = int'(sampleIn);
    if (!rst_n) begin
      mPrev = 0; mArmed = 0; mTrig = 0; mPulse = 0; mOut = 0;
    end else begin
      if (fastMode) begin
        fire = edgeAt(mPrev, cur, int'(fastSel[2:0]), !fastSel[3]);
      end else begin
        bit stateOk, anyEdge;
        stateOk = 1;
        for (int c = 0; c < 16; c++)
          if (matchMask[c] && (sampleIn[c] != matchValue[c])) stateOk = 0;
        anyEdge = 0;
        if (edgeEnA && edgeAt(mPrev, cur, int'(edgeSelA), edgeRiseA)) anyEdge = 1;
        if (edgeEnB && edgeAt(mPrev, cur, int'(edgeSelB), edgeRiseB)) anyEdge = 1;
        if (!edgeEnA && !edgeEnB) anyEdge = 1;
        fire = stateOk && anyEdge;
      end
      if (armStart) begin
        mArmed = 1; mTrig = 0; mPulse = 0; mOut = 0;
      end else if (mArmed && sampleEn && fire) begin
        mArmed = 0; mTrig = 1; mPulse = 1; mOut = trigOutEn;
      end else begin
        mPulse = 0; mOut = 0;
      end
      if (sampleEn) mPrev = cur;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(trigPulse == mPulse, "R11 pulse vs model", trigPulse, mPulse);
      check(trigOut == mOut, "R9 trigOut vs model", trigOut, mOut);
      check(modeStatus == {2'b00, mTrig, 4'b0000, mArmed}, "R8 status vs model",
            modeStatus, {2'b00, mTrig, 4'b0000, mArmed});
    end
  end

  task automatic arm();
    @(posedge clk); #2 armStart = 1'b1;
    @(posedge clk); #2 armStart = 1'b0;
  endtask

  // Present one qualified sample; after return, outputs reflect it
  task automatic samp(input logic [15:0] v, input bit expPulse, input string tag);
    @(posedge clk); #2 sampleIn = v; sampleEn = 1'b1;
    @(posedge clk); #2 sampleEn = 1'b0;
    check(trigPulse == expPulse, tag, trigPulse, expPulse);
  endtask

  task automatic idle(input logic [15:0] v);
    @(posedge clk); #2 sampleIn = v; sampleEn = 1'b0;
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(trigPulse == 0 && trigOut == 0 && modeStatus == 8'h00,
          "R1 reset outputs", {trigPulse, trigOut, modeStatus}, 0);
    rst_n = 1'b1;
    trigOutEn = 1'b1;
    matchMask = 16'h00F0; matchValue = 16'h0050;
    samp(16'hAB5C, 0, "R10 unarmed ignores match");
    arm();
    check(modeStatus == 8'h01, "R8 armed bit", modeStatus, 8'h01);
    samp(16'h1234, 0, "R2 mismatch no fire");
    samp(16'hAB5C, 1, "R2 masked match fires");
    check(modeStatus == 8'h20, "R8 triggered bit", modeStatus, 8'h20);
    check(trigOut == 1, "R9 trigOut enabled", trigOut, 1);
    samp(16'hAB5C, 0, "R10 no refire");
    check(modeStatus == 8'h20, "R8 flag sticky", modeStatus, 8'h20);
    arm();
    check(modeStatus == 8'h01, "R10 rearm clears flag", modeStatus, 8'h01);
    trigOutEn = 1'b0;
    samp(16'hFF5F, 1, "R2 unmasked bits don't care");
    check(trigOut == 0, "R9 trigOut disabled", trigOut, 0);

    // Rising edge on channel 3
    matchMask = 16'h0000; edgeEnA = 1; edgeSelA = 4'd3; edgeRiseA = 1;
    trigOutEn = 1'b1;
    arm();
    samp(16'h0000, 0, "R3 falling not rising");
    samp(16'h0008, 1, "R3 rising fires");

    // Previous sample held while sampleEn low
    arm();
    idle(16'h0000);
    samp(16'h0008, 0, "R6 idle clock does not load prev");
    samp(16'h0000, 0, "R6 fall ignored by rise detector");
    samp(16'h0008, 1, "R6 qualified edge fires");

    // Falling edge on channel 3
    edgeRiseA = 0;
    arm();
    samp(16'h0000, 1, "R4 falling fires");

    // Two detectors ORed, ANDed with state
    edgeSelA = 4'd1; edgeRiseA = 1;
    edgeEnB = 1; edgeSelB = 4'd9; edgeRiseB = 0;
    matchMask = 16'h8000; matchValue = 16'h8000;
    arm();
    samp(16'h0002, 0, "R5 edge without state");
    samp(16'h0000, 0, "R5 no edge");
    samp(16'h8200, 0, "R5 wrong polarity on B");
    samp(16'h8000, 1, "R5 B falling with state");
    arm();
    samp(16'h8002, 1, "R5 A rising with state");

    // Fast mode: pin 5
    fastMode = 1; fastSel = 4'b0101;
    matchMask = 16'hFFFF; matchValue = 16'hFFFF;
    arm();
    samp(16'h0000, 0, "R7 prep");
    samp(16'h0010, 0, "R7 other pin ignored");
    samp(16'h0030, 1, "R7 rising pin5 fires despite state");
    fastSel = 4'b1101;
    arm();
    samp(16'h0010, 1, "R7 falling pin5 fires");
    arm();
    samp(16'h0030, 0, "R7 rising ignored in falling mode");

    // Arm and match in the same cycle: arm wins
    fastMode = 0; edgeEnA = 0; edgeEnB = 0; matchMask = 16'h0000;
    @(posedge clk); #2 armStart = 1; sampleEn = 1;
    @(posedge clk); #2 armStart = 0; sampleEn = 0;
    check(trigPulse == 0 && modeStatus == 8'h01, "R10 arm priority",
          {trigPulse, modeStatus}, 8'h01);
    samp(16'h1111, 1, "R2 empty mask fires");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule